// File: doc/BRIEF.md
# Polling Receiver Power Sequencer

This block decides when a duty-cycled radio receiver is powered and listening. While polling, it sleeps for a programmed number of basic ticks. It then wakes the signal path for a start-up interval and asks an external bit-check unit to judge the incoming data. A failed judgement sends it back to sleep. A passed judgement holds it in continuous receiving until software or the host ends the session.

All timing is counted in basic ticks. A tick is one system clock out of every `DIV` clocks, so the default of 14 matches a crystal clock divided by 14. The sleep length is the 5-bit sleep word times an extension factor times a fixed unit of ticks. The extension factor is 1, or `XEXT` when the extension bit is set. The all-ones sleep word parks the block in sleep. The start-up length comes from a four-entry table selected by the baud-range code. A host-level mode pin can force continuous receiving at any moment.

Top module: `poll_seq_top`

## Requirements
- R1: A basic tick occurs once every `DIV` clocks, counted from reset release, and every interval of the block is a whole number of ticks.
- R2: With `sleep_ext`=0 and a sleep word W (0..30), sleep lasts W×`UNIT` ticks; a word of 0 leaves sleep on the first tick.
- R3: With `sleep_ext`=1, sleep lasts W×`XEXT`×`UNIT` ticks.
- R4: A sleep word of 31 holds the block in sleep for as long as that word is present and `poll_n_on` is high.
- R5: States follow sleep, then start-up, then bit-check. `chk_start` is high for exactly one clock, in the first clock of bit-check.
- R6: Start-up lasts `STUP0`, `STUP1`, `STUP2` or `STUP3` ticks for `baud_range` codes 0, 1, 2 and 3.
- R7: In bit-check, `chk_fail` returns the block to sleep on the next clock, and `chk_pass` enters receiving. When both are high, `chk_fail` wins.
- R8: `active` and `path_en` are low in sleep and high in start-up, bit-check and receiving.
- R9: A low `poll_n_on` puts the block in receiving on the next clock from any state, and `off_cmd` has no effect while it is low.
- R10: In receiving, either an `off_cmd` pulse or a rising edge on `poll_n_on` returns the block to sleep on the next clock. Otherwise the block stays in receiving.
- R11: When the sleep word changes from 31 to another value while the block is parked, start-up begins at the next tick.
- R12: Reset puts the block in sleep with its counters cleared and `chk_start` low.
- R13: `chk_pass` and `chk_fail` have no effect outside bit-check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, divided by `DIV` to form the tick |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_word | input | 5 | Sleep length multiplier; 31 parks the block |
| sleep_ext | input | 1 | Selects the extended sleep factor `XEXT` |
| baud_range | input | 2 | Selects the start-up table entry |
| poll_n_on | input | 1 | High: polling; low: force continuous receiving |
| off_cmd | input | 1 | One-clock request to leave receiving |
| chk_pass | input | 1 | Bit-check unit reports a valid signal |
| chk_fail | input | 1 | Bit-check unit reports no valid signal |
| active | output | 1 | Receiver awake indicator |
| path_en | output | 1 | Signal path power enable |
| chk_start | output | 1 | One-clock start strobe to the bit-check unit |

## Verification
The properties assume that `off_cmd` matters only in receiving, and that `chk_pass` and `chk_fail` come from a checker that was started. They also treat `poll_n_on` as a level that is held for several clocks. The stimulus drives every input at the falling clock edge. It gives pass and fail results only after it has seen `chk_start`, except where it deliberately pulses them during sleep to show that they are ignored. The mode pin is held for many clocks at each level, so each of its edges is a single clean transition.

// File: rtl/poll_seq_pkg.sv
package poll_seq_pkg;

    typedef enum logic [1:0] {
        ST_SLEEP   = 2'd0,
        ST_STARTUP = 2'd1,
        ST_CHECK   = 2'd2,
        ST_RECEIVE = 2'd3
    } pwr_state_e;

    localparam int SLEEP_W = 5;
    localparam logic [SLEEP_W-1:0] PARK_CODE = '1;

endpackage

// File: rtl/poll_tick_gen.sv
module poll_tick_gen #(
    parameter int DIV = 14
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/poll_dwell_calc.sv
module poll_dwell_calc
    import poll_seq_pkg::*;
#(
    parameter int UNIT  = 1024,
    parameter int XEXT  = 8,
    parameter int STUP0 = 96,
    parameter int STUP1 = 64,
    parameter int STUP2 = 48,
    parameter int STUP3 = 40,
    parameter int CNT_W = 18
) (
    input  logic [SLEEP_W-1:0] sleep_word,
    input  logic               sleep_ext,
    input  logic [1:0]         baud_range,
    output logic [CNT_W-1:0]   sleep_target,
    output logic [CNT_W-1:0]   stup_target
);
    localparam logic [CNT_W-1:0] UNIT_C = CNT_W'(UNIT);
    localparam logic [CNT_W-1:0] XEXT_C = CNT_W'(XEXT);

    logic [CNT_W-1:0] factor;

    generate
        if (XEXT > 1) begin : g_ext
            assign factor = sleep_ext ? XEXT_C : CNT_W'(1);
        end else begin : g_noext
            logic unused_ext;
            assign unused_ext = sleep_ext;
            assign factor = CNT_W'(1);
        end
    endgenerate

    always_comb begin
        sleep_target = CNT_W'(sleep_word) * factor * UNIT_C;
    end

    always_comb begin
        case (baud_range)
            2'd0:    stup_target = CNT_W'(STUP0);
            2'd1:    stup_target = CNT_W'(STUP1);
            2'd2:    stup_target = CNT_W'(STUP2);
            default: stup_target = CNT_W'(STUP3);
        endcase
    end
endmodule

// File: rtl/poll_seq_fsm.sv
module poll_seq_fsm
    import poll_seq_pkg::*;
#(
    parameter int CNT_W = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [SLEEP_W-1:0] sleep_word,
    input  logic [CNT_W-1:0]   sleep_target,
    input  logic [CNT_W-1:0]   stup_target,
    input  logic               poll_n_on,
    input  logic               off_cmd,
    input  logic               chk_pass,
    input  logic               chk_fail,
    output logic               awake,
    output logic               chk_start,
    output pwr_state_e         state
);
    typedef struct packed {
        pwr_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             parked;
        logic             start;
        logic             poll_last;
    } seq_t;

    seq_t cur_q, nxt_d;
    logic [CNT_W:0] cnt_inc;
    logic           poll_rise;

    always_comb begin
        cnt_inc   = {1'b0, cur_q.cnt} + 1'b1;
        poll_rise = poll_n_on && !cur_q.poll_last;

        nxt_d           = cur_q;
        nxt_d.start     = 1'b0;
        nxt_d.poll_last = poll_n_on;

        if (!poll_n_on) begin
            if (cur_q.st != ST_RECEIVE) begin
                nxt_d.st     = ST_RECEIVE;
                nxt_d.cnt    = '0;
                nxt_d.parked = 1'b0;
            end
        end else begin
            unique case (cur_q.st)
                ST_SLEEP: begin
                    if (tick) begin
                        if (sleep_word == PARK_CODE) begin
                            nxt_d.cnt    = '0;
                            nxt_d.parked = 1'b1;
                        end else if (cur_q.parked ||
                                     cnt_inc >= {1'b0, sleep_target}) begin
                            nxt_d.st     = ST_STARTUP;
                            nxt_d.cnt    = '0;
                            nxt_d.parked = 1'b0;
                        end else begin
                            nxt_d.cnt = cnt_inc[CNT_W-1:0];
                        end
                    end
                end
                ST_STARTUP: begin
                    if (tick) begin
                        if (cnt_inc >= {1'b0, stup_target}) begin
                            nxt_d.st    = ST_CHECK;
                            nxt_d.cnt   = '0;
                            nxt_d.start = 1'b1;
                        end else begin
                            nxt_d.cnt = cnt_inc[CNT_W-1:0];
                        end
                    end
                end
                ST_CHECK: begin
                    if (chk_fail) begin
                        nxt_d.st     = ST_SLEEP;
                        nxt_d.cnt    = '0;
                        nxt_d.parked = 1'b0;
                    end else if (chk_pass) begin
                        nxt_d.st = ST_RECEIVE;
                    end
                end
                default: begin
                    if (off_cmd || poll_rise) begin
                        nxt_d.st     = ST_SLEEP;
                        nxt_d.cnt    = '0;
                        nxt_d.parked = 1'b0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.st        <= ST_SLEEP;
            cur_q.cnt       <= '0;
            cur_q.parked    <= 1'b0;
            cur_q.start     <= 1'b0;
            cur_q.poll_last <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign awake     = (cur_q.st != ST_SLEEP);
    assign chk_start = cur_q.start;
    assign state     = cur_q.st;
endmodule

// File: rtl/poll_seq_top.sv
module poll_seq_top
    import poll_seq_pkg::*;
#(
    parameter int DIV   = 14,
    parameter int UNIT  = 1024,
    parameter int XEXT  = 8,
    parameter int STUP0 = 96,
    parameter int STUP1 = 64,
    parameter int STUP2 = 48,
    parameter int STUP3 = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] sleep_word,
    input  logic       sleep_ext,
    input  logic [1:0] baud_range,
    input  logic       poll_n_on,
    input  logic       off_cmd,
    input  logic       chk_pass,
    input  logic       chk_fail,
    output logic       active,
    output logic       path_en,
    output logic       chk_start
);
    localparam int XMAX  = (XEXT > 1) ? XEXT : 1;
    localparam int CNT_W = $clog2(((2 ** SLEEP_W) - 1) * XMAX * UNIT + 1);

    logic             tick;
    logic             awake;
    logic [CNT_W-1:0] sleep_target;
    logic [CNT_W-1:0] stup_target;
    pwr_state_e       fsm_state;

    poll_tick_gen #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    poll_dwell_calc #(
        .UNIT (UNIT),
        .XEXT (XEXT),
        .STUP0(STUP0),
        .STUP1(STUP1),
        .STUP2(STUP2),
        .STUP3(STUP3),
        .CNT_W(CNT_W)
    ) u_dwell (
        .sleep_word  (sleep_word),
        .sleep_ext   (sleep_ext),
        .baud_range  (baud_range),
        .sleep_target(sleep_target),
        .stup_target (stup_target)
    );

    poll_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .sleep_word  (sleep_word),
        .sleep_target(sleep_target),
        .stup_target (stup_target),
        .poll_n_on   (poll_n_on),
        .off_cmd     (off_cmd),
        .chk_pass    (chk_pass),
        .chk_fail    (chk_fail),
        .awake       (awake),
        .chk_start   (chk_start),
        .state       (fsm_state)
    );

    assign active  = awake;
    assign path_en = awake;
endmodule

// File: rtl/poll_seq_chk.sv
module poll_seq_chk
    import poll_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] sleep_word,
    input logic       poll_n_on,
    input logic       off_cmd,
    input logic       chk_pass,
    input logic       chk_fail,
    input logic       active,
    input logic       chk_start,
    input pwr_state_e state
);
    AST_START_IN_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        chk_start |-> (state == ST_CHECK && active)); // R5

    AST_START_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        chk_start |=> !chk_start); // R5

    AST_WAKE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && poll_n_on) |=> (state == ST_SLEEP || state == ST_STARTUP)); // R5

    AST_PARK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && sleep_word == PARK_CODE && poll_n_on) |=> !active); // R4

    AST_FAIL_SLEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK && chk_fail && poll_n_on) |=> !active); // R7

    AST_PASS_RECEIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK && chk_pass && !chk_fail) |=> (state == ST_RECEIVE)); // R7

    AST_FORCE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        !poll_n_on |=> (active && state == ST_RECEIVE)); // R9

    AST_OFF_SLEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECEIVE && poll_n_on && off_cmd) |=> !active); // R10
endmodule

bind poll_seq_top poll_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_word(sleep_word),
    .poll_n_on (poll_n_on),
    .off_cmd   (off_cmd),
    .chk_pass  (chk_pass),
    .chk_fail  (chk_fail),
    .active    (active),
    .chk_start (chk_start),
    .state     (fsm_state)
);

// File: tb/tb_poll_seq_top.sv
module tb_poll_seq_top;
    localparam int DIV = 4;
    localparam int UNIT = 8;
    localparam int XEXT = 8;
    localparam int STUP [4] = '{6, 5, 4, 3};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] sleep_word = 5'd2;
    logic sleep_ext = 1'b0;
    logic [1:0] baud_range = 2'd0;
    logic poll_n_on = 1'b1;
    logic off_cmd = 1'b0;
    logic chk_pass = 1'b0;
    logic chk_fail = 1'b0;
    logic active, path_en, chk_start;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    poll_seq_top #(
        .DIV(DIV), .UNIT(UNIT), .XEXT(XEXT),
        .STUP0(STUP[0]), .STUP1(STUP[1]), .STUP2(STUP[2]), .STUP3(STUP[3])
    ) dut (
        .clk(clk), .rst_n(rst_n), .sleep_word(sleep_word), .sleep_ext(sleep_ext),
        .baud_range(baud_range), .poll_n_on(poll_n_on), .off_cmd(off_cmd),
        .chk_pass(chk_pass), .chk_fail(chk_fail),
        .active(active), .path_en(path_en), .chk_start(chk_start)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_active(input logic lvl, input int maxc, output int n);
        n = 0;
        while (active !== lvl && n < maxc) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_start(input int maxc, output int n);
        n = 0;
        while (chk_start !== 1'b1 && n < maxc) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    task automatic t_reset_and_first_cycle();
        int n;
        repeat (5) @(negedge clk);
        check(active === 1'b0 && path_en === 1'b0 && chk_start === 1'b0, "R12 reset outputs",
              {active, path_en, chk_start}, 0);
        rst_n = 1'b1;
        wait_active(1'b1, 1000, n);
        check(n == 2 * UNIT * DIV, "R1 R2 R12 sleep from reset", n, 2 * UNIT * DIV);
        check(path_en === 1'b1, "R8 path_en in startup", path_en, 1);
        wait_start(1000, n);
        check(n == STUP[0] * DIV, "R5 R6 startup range0", n, STUP[0] * DIV);
        @(negedge clk);
        check(chk_start === 1'b0 && active === 1'b1, "R5 start pulse one clock", chk_start, 0);
    endtask

    task automatic t_fail_then_pass();
        int n;
        chk_fail = 1'b1;
        @(negedge clk);
        chk_fail = 1'b0;
        check(active === 1'b0 && path_en === 1'b0, "R7 R8 fail to sleep", active, 0);
        wait_active(1'b1, 1000, n);
        check(n >= (2 * UNIT - 1) * DIV + 1 && n <= 2 * UNIT * DIV, "R2 sleep length", n,
              2 * UNIT * DIV);
        wait_start(1000, n);
        @(negedge clk);
        pulse(chk_pass);
        repeat (100) @(negedge clk);
        check(active === 1'b1, "R7 R10 pass holds receiving", active, 1);
        pulse(off_cmd);
        check(active === 1'b0, "R10 off command to sleep", active, 0);
    endtask

    task automatic t_extension();
        int n;
        sleep_word = 5'd1;
        sleep_ext = 1'b1;
        wait_active(1'b1, 2000, n);
        check(n >= (XEXT * UNIT - 1) * DIV + 1 && n <= XEXT * UNIT * DIV, "R3 extended sleep",
              n, XEXT * UNIT * DIV);
        sleep_ext = 1'b0;
        wait_start(1000, n);
        @(negedge clk);
        chk_pass = 1'b1;
        chk_fail = 1'b1;
        @(negedge clk);
        chk_pass = 1'b0;
        chk_fail = 1'b0;
        check(active === 1'b0, "R7 fail wins over pass", active, 0);
    endtask

    task automatic t_park();
        int n;
        sleep_word = 5'd31;
        repeat (200) @(negedge clk);
        pulse(chk_pass);
        pulse(chk_fail);
        repeat (300) @(negedge clk);
        check(active === 1'b0, "R4 R13 parked sleep ignores results", active, 0);
        sleep_word = 5'd1;
        wait_active(1'b1, 100, n);
        check(n >= 1 && n <= DIV, "R11 wake after unpark", n, DIV);
        wait_start(1000, n);
        check(n == STUP[0] * DIV, "R11 R6 startup after unpark", n, STUP[0] * DIV);
        @(negedge clk);
    endtask

    task automatic t_ranges();
        int n;
        sleep_word = 5'd0;
        for (int r = 0; r < 4; r++) begin
            baud_range = 2'(r);
            pulse(chk_fail);
            wait_active(1'b1, 100, n);
            check(n >= 1 && n <= DIV, "R2 zero sleep word", n, DIV);
            wait_start(1000, n);
            check(n == STUP[r] * DIV, "R6 startup per range", n, STUP[r] * DIV);
            @(negedge clk);
        end
    endtask

    task automatic t_mode_pin();
        sleep_word = 5'd31;
        pulse(chk_fail);
        repeat (20) @(negedge clk);
        poll_n_on = 1'b0;
        @(negedge clk);
        check(active === 1'b1, "R9 low pin forces receiving", active, 1);
        pulse(off_cmd);
        repeat (3) @(negedge clk);
        check(active === 1'b1, "R9 off ignored while pin low", active, 1);
        poll_n_on = 1'b1;
        @(negedge clk);
        check(active === 1'b0, "R10 pin rise to sleep", active, 0);
        repeat (100) @(negedge clk);
        check(active === 1'b0, "R4 parked after pin rise", active, 0);
    endtask

    initial begin
        t_reset_and_first_cycle();
        t_fail_then_pass();
        t_extension();
        t_park();
        t_ranges();
        t_mode_pin();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule